// File: doc/BRIEF.md
# Hot-Swap Switch Enable Controller with Auto-Retry

This block decides, one clock at a time, whether the pass switch of a single hot-swap channel may be driven on. It takes the on request, the live fault status, the sticky fault bits held in an external fault register, and one auto-retry enable per fault kind. It returns a registered switch enable, a one-cycle request for the fault register to set its overcurrent bit, and a flag that shows a cool-down period is running.

The auto-retry enable of each fault kind picks what holds the switch off. With retry disabled, the sticky fault bit blocks the switch until software clears it. With retry enabled for overvoltage or undervoltage, only the live status blocks it. An overcurrent event while the switch is on always turns the switch off, asks for the sticky overcurrent bit to be set, and starts a cool-down of `COOL_CYCLES` clocks. With overcurrent retry enabled, the switch is tried again after every cool-down, for as long as the current stays too high. The block never clears a fault bit.

Fault vectors use one bit order everywhere: bit 0 overvoltage, bit 1 undervoltage, bit 2 overcurrent.

Top module: `hs_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, `sw_en`, `oc_set_req` and `cool_busy` are 0.
- R2: If `on_req` is 0 at a clock edge, `sw_en` is 0 after that edge.
- R3: With `retry_en[0]` at 0 and `fault_bits[0]` at 1, or with `retry_en[1]` at 0 and `fault_bits[1]` at 1, or with `retry_en[2]` at 0 and `fault_bits[2]` at 1, `sw_en` is 0 after the next edge.
- R4: With retry disabled, when the blocking sticky bit clears while `on_req` is 1 and nothing else blocks, `sw_en` goes to 1 one edge later.
- R5: With `retry_en[0]` at 1, `live_stat[0]` holds the switch off and `fault_bits[0]` has no effect. The same applies to `retry_en[1]`, `live_stat[1]` and `fault_bits[1]`. With `retry_en[2]` at 1, `fault_bits[2]` has no effect.
- R6: With retry enabled, once `live_stat[0]` and `live_stat[1]` are both 0, `sw_en` goes to 1 one edge later, provided `on_req` is 1 and nothing else blocks.
- R7: If `sw_en` is 1 and `live_stat[2]` is 1 at an edge, then after that edge `sw_en` is 0 and `oc_set_req` is 1 for exactly one cycle. `oc_set_req` is never 1 at any other time.
- R8: After an overcurrent trip, `cool_busy` is 1 for exactly `COOL_CYCLES` cycles and `sw_en` stays 0 throughout. With `retry_en[2]` at 1, `sw_en` returns to 1 one cycle after `cool_busy` falls, provided nothing else blocks.
- R9: With `retry_en[2]` at 1 and `live_stat[2]` held at 1, the block keeps turning the switch on after each cool-down and tripping again, which produces repeated `oc_set_req` pulses.
- R10: If the switch is on after an auto-retry with `fault_bits[2]` at 1, clearing `retry_en[2]` turns `sw_en` off at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Channel on request |
| live_stat | input | 3 | Live fault status: bit 0 OV, bit 1 UV, bit 2 OC |
| fault_bits | input | 3 | Sticky fault register bits, same order |
| retry_en | input | 3 | Auto-retry enable per fault kind, same order |
| sw_en | output | 1 | Registered pass switch enable |
| oc_set_req | output | 1 | One-cycle request to set the sticky OC bit |
| cool_busy | output | 1 | Cool-down period in progress |

## Verification
The assertions check on every cycle the rules that fit within one clock step. These are that a low request turns the switch off (R2), that a sticky bit blocks the switch when its retry is off (R3, R10) and a live bit blocks it when its retry is on (R5), that a trip turns the switch off and a set request appears only after a trip (R7), and that the switch stays off while a cool-down runs (R8). Only the bench scenarios can show the things that span many cycles or depend on a release. These are the exact length of a cool-down, the switch turning on again one cycle after a sticky bit or live bit clears, the repeated trips while overcurrent persists (R9), and that a sticky bit is ignored while its retry is enabled.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned NUM_FLT = 3;
  localparam int unsigned FLT_OV  = 0;
  localparam int unsigned FLT_UV  = 1;
  localparam int unsigned FLT_OC  = 2;

  // Hold-off decision for one fault kind.
  // Voltage faults: retry picks live status, otherwise the sticky bit.
  // Overcurrent: retry lets the cool-down timer pace restarts, so only the
  // sticky bit with retry off blocks here.
  function automatic logic fault_holds(input logic is_oc, input logic retry,
                                       input logic live, input logic sticky);
    if (is_oc) return (!retry) && sticky;
    return retry ? live : sticky;
  endfunction
endpackage

// File: rtl/hs_holdoff.sv
module hs_holdoff #(
  parameter int unsigned NF = hs_pkg::NUM_FLT
) (
  input  logic [NF-1:0] live,
  input  logic [NF-1:0] sticky,
  input  logic [NF-1:0] retry,
  output logic [NF-1:0] hold_vec
);
  for (genvar g = 0; g < NF; g++) begin : g_flt
    localparam logic IS_OC = (g == hs_pkg::FLT_OC);
    assign hold_vec[g] = hs_pkg::fault_holds(IS_OC, retry[g], live[g], sticky[g]);
  end
endmodule

// File: rtl/hs_cooldown.sv
module hs_cooldown #(
  parameter int unsigned COOL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(COOL_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(COOL_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/hs_gate_ctrl.sv
module hs_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic hold_any,
  input  logic cooling,
  input  logic oc_live,
  output logic trip_evt,
  output logic sw_en,
  output logic oc_set_req
);
  logic sw_d;

  assign trip_evt = sw_en & oc_live;
  assign sw_d     = on_req & ~hold_any & ~cooling & ~trip_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en      <= 1'b0;
      oc_set_req <= 1'b0;
    end else begin
      sw_en      <= sw_d;
      oc_set_req <= trip_evt;
    end
  end
endmodule

// File: rtl/hs_switch_ctrl.sv
module hs_switch_ctrl #(
  parameter int unsigned COOL_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_req,
  input  logic [2:0] live_stat,
  input  logic [2:0] fault_bits,
  input  logic [2:0] retry_en,
  output logic       sw_en,
  output logic       oc_set_req,
  output logic       cool_busy
);
  localparam int unsigned NF = hs_pkg::NUM_FLT;

  logic [NF-1:0] hold_vec;
  logic          hold_any;
  logic          trip_evt;

  hs_holdoff #(.NF(NF)) u_hold (
    .live     (live_stat),
    .sticky   (fault_bits),
    .retry    (retry_en),
    .hold_vec (hold_vec)
  );

  assign hold_any = |hold_vec;

  hs_cooldown #(.COOL_CYCLES(COOL_CYCLES)) u_cool (
    .clk   (clk),
    .rst_n (rst_n),
    .start (trip_evt),
    .busy  (cool_busy)
  );

  hs_gate_ctrl u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_req     (on_req),
    .hold_any   (hold_any),
    .cooling    (cool_busy),
    .oc_live    (live_stat[hs_pkg::FLT_OC]),
    .trip_evt   (trip_evt),
    .sw_en      (sw_en),
    .oc_set_req (oc_set_req)
  );
endmodule

// File: rtl/hs_switch_ctrl_chk.sv
module hs_switch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       on_req,
  input logic [2:0] live_stat,
  input logic [2:0] fault_bits,
  input logic [2:0] retry_en,
  input logic       sw_en,
  input logic       oc_set_req,
  input logic       cool_busy
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!sw_en && !oc_set_req && !cool_busy) || !rst_n);

  a_r2_on_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !on_req |=> !sw_en);

  a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((!retry_en[0] && fault_bits[0]) || (!retry_en[1] && fault_bits[1])) |=> !sw_en);

  a_r5_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((retry_en[0] && live_stat[0]) || (retry_en[1] && live_stat[1])) |=> !sw_en);

  a_r7_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && live_stat[2]) |=> (!sw_en && oc_set_req));

  a_r7_set_after_trip: assert property (@(posedge clk) disable iff (!rst_n)
    oc_set_req |-> $past(sw_en && live_stat[2]));

  a_r8_off_while_cooling: assert property (@(posedge clk) disable iff (!rst_n)
    cool_busy |-> !sw_en);

  a_r10_sticky_oc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!retry_en[2] && fault_bits[2]) |=> !sw_en);
endmodule

bind hs_switch_ctrl hs_switch_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .on_req     (on_req),
  .live_stat  (live_stat),
  .fault_bits (fault_bits),
  .retry_en   (retry_en),
  .sw_en      (sw_en),
  .oc_set_req (oc_set_req),
  .cool_busy  (cool_busy)
);

// File: tb/hs_switch_ctrl_tb_top.sv
module hs_switch_ctrl_tb_top;
  localparam int COOL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       on_req = 1'b0;
  logic [2:0] live_stat = '0;
  logic [2:0] fault_bits = '0;
  logic [2:0] retry_en = '0;
  logic       sw_en, oc_set_req, cool_busy;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "R1";

  // behavioural reference state
  int m_sw = 0, m_set = 0, m_cnt = 0;

  always #5 clk = ~clk;

  hs_switch_ctrl #(.COOL_CYCLES(COOL)) dut_i (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .live_stat(live_stat),
    .fault_bits(fault_bits), .retry_en(retry_en),
    .sw_en(sw_en), .oc_set_req(oc_set_req), .cool_busy(cool_busy)
  );

  // reference model: written from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sw = 0; m_set = 0; m_cnt = 0;
    end else begin
      bit blocked, trip;
      blocked = !on_req;
      if (retry_en[0] ? live_stat[0] : fault_bits[0]) blocked = 1;
      if (retry_en[1] ? live_stat[1] : fault_bits[1]) blocked = 1;
      if (!retry_en[2] && fault_bits[2]) blocked = 1;
      if (m_cnt > 0) blocked = 1;
      trip = (m_sw == 1) && live_stat[2];
      m_set = trip;
      if (trip) m_cnt = COOL;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_sw = (!blocked && !trip) ? 1 : 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, "model sw_en", sw_en, m_sw);
      check(phase, "model oc_set_req", oc_set_req, m_set);
      check(phase, "model cool_busy", cool_busy, (m_cnt > 0) ? 1 : 0);
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int pulses;
    int busy_len;
    tick(3);
    check("R1", "sw_en in reset", sw_en, 0);
    check("R1", "oc_set_req in reset", oc_set_req, 0);
    check("R1", "cool_busy in reset", cool_busy, 0);
    rst_n = 1'b1;

    // R2
    phase = "R2";
    on_req = 1; tick();
    check("R2", "on with request", sw_en, 1);
    on_req = 0; tick();
    check("R2", "off without request", sw_en, 0);
    on_req = 1; tick();

    // R3 / R4 with retry disabled
    phase = "R3";
    retry_en = 3'b000;
    for (int b = 0; b < 3; b++) begin
      fault_bits = 3'b001 << b; tick();
      check("R3", "sticky bit holds off", sw_en, 0);
      tick(2);
      check("R3", "sticky bit still holds", sw_en, 0);
      fault_bits = '0; tick();
      check("R4", "release on clear", sw_en, 1);
    end

    // R5 / R6 with voltage retry enabled
    phase = "R5";
    retry_en = 3'b011; fault_bits = 3'b011; tick();
    check("R5", "sticky ignored under retry", sw_en, 1);
    for (int b = 0; b < 2; b++) begin
      live_stat = 3'b001 << b; tick();
      check("R5", "live bit holds off", sw_en, 0);
      live_stat = '0; tick();
      check("R6", "release when live clears", sw_en, 1);
    end
    fault_bits = '0;

    // R7 / R8 overcurrent trip with retry
    phase = "R7";
    retry_en = 3'b111; tick();
    live_stat = 3'b100; tick();
    check("R7", "trip turns off", sw_en, 0);
    check("R7", "set request pulse", oc_set_req, 1);
    live_stat = '0;
    busy_len = 0;
    phase = "R8";
    while (cool_busy && busy_len < 10 * COOL) begin
      busy_len++;
      check("R8", "off while cooling", sw_en, 0);
      if (busy_len == 2) check("R7", "set request single cycle", oc_set_req, 0);
      tick();
    end
    check("R8", "cool-down length", busy_len, COOL);
    check("R8", "still off as cool-down ends", sw_en, 0);
    tick();
    check("R8", "retry after cool-down", sw_en, 1);

    // R9 persistent overcurrent
    phase = "R9";
    live_stat = 3'b100;
    pulses = 0;
    for (int i = 0; i < 3 * (COOL + 2); i++) begin
      tick();
      if (oc_set_req) pulses++;
    end
    check("R9", "repeated trips", (pulses >= 2) ? 1 : 0, 1);
    live_stat = '0; tick(COOL + 3);
    check("R9", "on after overcurrent goes away", sw_en, 1);

    // R10 clearing OC retry with sticky bit set
    phase = "R10";
    fault_bits = 3'b100; tick();
    check("R5", "sticky OC ignored under retry", sw_en, 1);
    retry_en = 3'b011; tick();
    check("R10", "retry cleared turns off", sw_en, 0);
    retry_en = 3'b111; tick();
    check("R10", "retry restored turns on", sw_en, 1);
    fault_bits = '0;

    // R3 overcurrent with retry disabled: bench acts as fault register
    phase = "R3";
    retry_en = 3'b000; live_stat = 3'b100; tick();
    check("R7", "trip without retry", oc_set_req, 1);
    fault_bits = 3'b100; live_stat = '0; tick(COOL + 4);
    check("R3", "sticky OC holds past cool-down", sw_en, 0);
    fault_bits = '0; tick();
    check("R4", "release on OC clear", sw_en, 1);

    // mixed patterns, compared against the model every cycle
    phase = "R2-mix";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      on_req     = (r % 8) != 0;
      live_stat  = ((r >> 4) % 5 == 0) ? 3'((r >> 8)) : 3'b000;
      fault_bits = ((r >> 12) % 6 == 0) ? 3'((r >> 16)) : 3'b000;
      if ((r >> 20) % 50 == 0) retry_en = 3'((r >> 24));
      tick();
    end
    finish_run();
  end
endmodule